// File: doc/BRIEF.md
# DRAM Strobe Decoder with Parallel Test Mode

This block is a clocked model of the control logic of a small x4 dynamic memory. It samples the active-low row strobe, column strobe, write enable and output enable on a system clock. The row address is captured when the row strobe goes low, and the column address is captured each time the column strobe goes low. The order in which the strobes fall decides what kind of cycle is running: an ordinary access, a refresh started by the column strobe, a refresh using the row strobe alone, or the cycle that enters test mode. The cells sit in a small internal array.

Test mode speeds up checking the array after manufacture. It is entered when the column strobe and write enable are both low before the row strobe falls. In test mode the two lowest column bits are ignored. A write copies each data bit into four cells at once. A read does not return stored data. Instead each data line reports whether its four cells agree. Either refresh that does not hold write enable low returns the device to normal operation. Data in and data out are separate buses, and an output-enable flag marks when the output would drive the pins.

Top module: `dram_ptm`

## Requirements
- R1: After reset the device is in normal mode (`test_mode` = 0) and `dq_oe` is 0.
- R2: In normal mode, a write at row `r` (address sampled when `ras_n` falls) and column `c` (address sampled when `cas_n` falls) is returned by a later read of the same `r`, `c` on `dq_out`.
- R3: `dq_oe` is 0 whenever `oe_n`, `cas_n` or `ras_n` is high. It is 1 during a read once the column address has been taken and all three strobes are low.
- R4: A `ras_n` fall with `cas_n` low and `we_n` low sets `test_mode` to 1.
- R5: In test mode, a write stores bit `i` of `dq_in` into bit `i` of the four cells of the addressed row whose column differs only in bits [1:0]. The column's bits [1:0] have no effect.
- R6: In test mode, a read drives bit `i` of `dq_out` to 1 when bit `i` of the four grouped cells is all ones or all zeros, and to 0 otherwise.
- R7: In test mode, ordinary read cycles and further `ras_n` falls with `cas_n` and `we_n` low leave `test_mode` at 1.
- R8: A `ras_n` fall with `cas_n` low and `we_n` high clears `test_mode`. So does a `ras_n` low period in which `cas_n` never falls; `test_mode` clears when `ras_n` rises again.
- R9: Both kinds of refresh cycle leave every stored cell unchanged.
- R10: A write is performed when `we_n` is low at the `cas_n` fall. It is also performed when `we_n` falls later while `cas_n` and `ras_n` are still low. In that delayed case, `dq_in` is taken on the clock where the `we_n` fall is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed address; AW = max(ROW_W, COL_W) |
| dq_in | input | IO_W | Write data |
| dq_out | output | IO_W | Read data, or the per-line agreement flags in test mode |
| dq_oe | output | 1 | High when `dq_out` would drive the pins |
| test_mode | output | 1 | High while parallel test mode is active |

## Verification
The bench builds the block with its defaults: eight rows, sixteen columns and four data lines. That gives four column groups per row, so a single row holds both a uniform group and a group spoiled by one normal-mode write. The bench writes a pattern in test mode, leaves test mode, overwrites one cell, and then re-enters test mode. This exercises agreement flags that are high on some lines and low on others in the same read, and checks them against a reference model. Delayed writes, both exits from test mode, and whether refreshes preserve data all sit within the same small array.

// File: rtl/dram_ptm.sv
module dram_ptm #(
  parameter int ROW_W = 3,
  parameter int COL_W = 4,
  parameter int IO_W  = 4,
  localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [IO_W-1:0] dq_in,
  output logic [IO_W-1:0] dq_out,
  output logic            dq_oe,
  output logic            test_mode
);
  localparam int DEPTH = 1 << (ROW_W + COL_W);
  localparam int GRP_W = COL_W - 2;

  logic [IO_W-1:0]  mem [DEPTH];
  logic             ras_q, cas_q, we_q, active, cas_seen, tm;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col, col_now;
  logic [IO_W-1:0]  flags;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & active & ~ras_n;
  wire we_fall  = we_q & ~we_n;
  wire do_wr    = active & ~ras_n &
                  ((cas_fall & ~we_n) | (cas_seen & ~cas_n & we_fall));

  assign col_now   = cas_fall ? addr[COL_W-1:0] : col;
  assign test_mode = tm;
  assign dq_oe     = active & cas_seen & ~ras_n & ~cas_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      active   <= 1'b0;
      cas_seen <= 1'b0;
      tm       <= 1'b0;
      row      <= '0;
      col      <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) begin
        if (!cas_n) begin
          tm <= ~we_n;
        end else begin
          active <= 1'b1;
          row    <= addr[ROW_W-1:0];
        end
      end
      if (ras_rise) begin
        active   <= 1'b0;
        cas_seen <= 1'b0;
        if (active && !cas_seen) tm <= 1'b0;
      end
      if (cas_fall) begin
        col      <= addr[COL_W-1:0];
        cas_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      if (tm) begin
        for (int k = 0; k < 4; k++)
          mem[{row, col_now[COL_W-1:2], 2'(k)}] <= dq_in;
      end else begin
        mem[{row, col_now}] <= dq_in;
      end
    end
  end

  wire [GRP_W-1:0] grp = col[COL_W-1:2];

  for (genvar i = 0; i < IO_W; i++) begin : g_flag
    logic [3:0] bits;
    for (genvar k = 0; k < 4; k++) begin : g_cell
      assign bits[k] = mem[{row, grp, 2'(k)}][i];
    end
    assign flags[i] = (&bits) | ~(|bits);
  end

  assign dq_out = tm ? flags : mem[{row, col}];
endmodule

// File: rtl/dram_ptm_chk.sv
module dram_ptm_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic test_mode
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> !test_mode);

  // R3
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n || cas_n || oe_n) |-> !dq_oe);

  // R4
  wcbr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && !we_n) |=> test_mode);

  // R8
  cbr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && we_n) |=> !test_mode);

  // R7
  row_open_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && $fell(ras_n) && cas_n) |=> test_mode);
endmodule

bind dram_ptm dram_ptm_chk chk_i (.*);

// File: tb/dram_ptm_tb_top.sv
module dram_ptm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3, COL_W = 4, IO_W = 4;
  localparam int AW = 4;
  localparam int COLS = 1 << COL_W;

  typedef struct {
    logic            oe;
    logic [IO_W-1:0] d;
    string           req;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0]   addr = '0;
  logic [IO_W-1:0] dq_in = '0;
  logic [IO_W-1:0] dq_out;
  logic dq_oe, test_mode;
  logic mon_en = 0;
  int checks = 0, errors = 0;
  item_t exp_q[$];
  logic [IO_W-1:0] refm [1 << (ROW_W + COL_W)];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_ptm #(.ROW_W(ROW_W), .COL_W(COL_W), .IO_W(IO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .test_mode(test_mode));

  always @(negedge clk) begin
    if (mon_en) begin
      item_t e;
      e = exp_q.pop_front();
      checks++;
      if (dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
        errors++;
        $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h",
                 e.req, dq_oe, dq_out, e.oe, e.d);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int idx(int r, int c);
    return r * COLS + c;
  endfunction

  function automatic logic [IO_W-1:0] tflag(int r, int c);
    logic [IO_W-1:0] f;
    for (int i = 0; i < IO_W; i++) begin
      logic [3:0] b;
      for (int k = 0; k < 4; k++) b[k] = refm[idx(r, (c & ~3) + k)][i];
      f[i] = (&b) | ~(|b);
    end
    return f;
  endfunction

  task automatic release_all();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
    step();
  endtask

  task automatic wr(int r, int c, logic [IO_W-1:0] d);
    ras_n = 0; addr = AW'(r); step();
    cas_n = 0; we_n = 0; addr = AW'(c); dq_in = d; step();
    if (test_mode) for (int k = 0; k < 4; k++) refm[idx(r, (c & ~3) + k)] = d;
    else refm[idx(r, c)] = d;
    release_all();
  endtask

  // R10 delayed write: WE falls after CAS
  task automatic dwr(int r, int c, logic [IO_W-1:0] d);
    ras_n = 0; addr = AW'(r); step();
    cas_n = 0; addr = AW'(c); dq_in = ~d; step();
    we_n = 0; dq_in = d; step();
    dq_in = ~d; step();
    refm[idx(r, c)] = d;
    release_all();
  endtask

  task automatic rd(int r, int c, input string req, input logic oe_on = 1);
    item_t e;
    ras_n = 0; addr = AW'(r); step();
    cas_n = 0; oe_n = ~oe_on; addr = AW'(c); step();
    e.oe = oe_on;
    e.d = test_mode ? tflag(r, c) : refm[idx(r, c)];
    e.req = req;
    exp_q.push_back(e);
    mon_en = 1; step();
    mon_en = 0;
    release_all();
  endtask

  task automatic wcbr();
    cas_n = 0; we_n = 0; step();
    ras_n = 0; step();
    release_all();
  endtask

  task automatic cbr();
    cas_n = 0; we_n = 1; step();
    ras_n = 0; step(); step();
    release_all();
  endtask

  task automatic ras_only(int r);
    ras_n = 0; addr = AW'(r); step(); step();
    release_all();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << (ROW_W + COL_W)); i++) refm[i] = '0;
    step(); step();
    // R1
    chk(test_mode, 1'b0, "R1");
    chk(dq_oe, 1'b0, "R1");
    rst_n = 1; step();
    chk(test_mode, 1'b0, "R1");

    // R2: normal writes and reads on a whole row
    for (int c = 0; c < COLS; c++) wr(2, c, IO_W'(c ^ 5));
    for (int c = 0; c < COLS; c += 3) rd(2, c, "R2");
    for (int c = 0; c < COLS; c++) wr(1, c, '0);

    // R10
    dwr(3, 7, 4'hA);
    rd(3, 7, "R10");

    // R3: OE held high during a read
    rd(2, 4, "R3", 1'b0);

    // R4
    wcbr();
    chk(test_mode, 1'b1, "R4");

    // R5: test writes, low column bits differ from group base
    wr(1, 6, 4'b1010);
    wr(1, 11, 4'b0101);
    rd(1, 4, "R6");
    rd(1, 9, "R6");
    // R7
    chk(test_mode, 1'b1, "R7");
    wcbr();
    chk(test_mode, 1'b1, "R7");

    // R8: CBR exits
    cbr();
    chk(test_mode, 1'b0, "R8");
    // R5: every grouped cell holds the test-written data
    for (int k = 4; k < 8; k++) rd(1, k, "R5");
    rd(1, 8, "R5");

    // corrupt one cell with a normal write
    wr(1, 5, 4'b1100);

    // R9: refreshes keep data
    ras_only(1);
    cbr();
    rd(1, 5, "R9");
    rd(2, 13, "R9");
    rd(3, 7, "R9");

    // R6: mixed agreement flags
    wcbr();
    chk(test_mode, 1'b1, "R4");
    rd(1, 7, "R6");
    rd(1, 10, "R6");
    rd(2, 0, "R6");
    chk(tflag(1, 4), 4'b1001, "R6");

    // R8: RAS-only exits
    ras_only(0);
    chk(test_mode, 1'b0, "R8");
    rd(1, 5, "R8");

    step(); step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule